// File: doc/BRIEF.md
# Interleaved Priority Interrupt Controller

This block collects interrupt requests for a processor core from two families of sources: a set of active-low external pins and an equal number of internal levels. Four on-chip peripherals (periodic timer, real-time clock, time base and communication module) reach the internal levels through programmable 3-bit selectors. Every request lands in a pending register. A mask register gates the pending bits. The block raises one maskable request line to the core whenever an enabled source is pending. Pin 0 and a watchdog input bypass the mask and drive a separate non-maskable line.

Pins and levels share one fixed ranking that alternates pin, level, pin, level, from index 0 upward. A pin therefore always outranks the internal level with the same index. A registered code reports the best enabled pending source as its rank times four, so software can use the code directly as a table offset. Each pin can be set to edge capture, where the bit stays set until software clears it by writing a 1, or to level mode, where the bit tracks the pin.

There is no data stream in this block. All pins are plain control and status, with no valid/ready handshake and no back-pressure.

Top module: `ilv_intc`

## Requirements
- R1: The pending and mask bit for pin k is bit 2k, and for internal level k it is bit 2k+1. A lower bit index has higher priority, so a pin beats the level of the same index.
- R2: `int_code` is {2'b00, rank, 2'b00}, which is rank times four. Its two low bits are always zero and it never reaches 8'h40. It reads 8'h00 when no source qualifies.
- R3: `irq_o` is high exactly when a pending bit among bits 1 to 15 has its mask bit set. It is updated one cycle after the pending and mask state it reflects.
- R4: `irq_o` and `int_code` drop one cycle after the last enabled pending bit goes away, whether it was cleared or masked.
- R5: In edge mode (`irq_edge_mode[k]`=1), a high-to-low transition of `irq_pin_n[k]` sets the bit. The bit stays set after the pin returns high and is cleared only by a write of 1 to that bit. A pin held low does not set the bit again. A new edge in the same cycle as a clear leaves the bit set.
- R6: In level mode (`irq_edge_mode[k]`=0), the bit equals the inverted synchronized pin, and clear writes have no effect on it.
- R7: A pin change reaches `pend_o` on the third rising clock edge after it is applied. It reaches `irq_o` and `int_code` on the fourth.
- R8: `nmi_o` is high one cycle after pending bit 0 is set or `wdog_in` is registered high. It ignores mask bit 0. Pending bit 0 never drives `irq_o`, although it still takes part in the code, as rank 0.
- R9: Peripheral p (0 periodic timer, 1 real-time clock, 2 time base, 3 communication module) drives internal level `periph_lvl_sel[3p+2:3p]` while `periph_req[p]` is high. Several peripherals on one level are ORed. The level pending bit is registered one cycle after the request.
- R10: When `cfg_wr_en`=1 and `cfg_wr_sel`=1, `cfg_wr_data` loads the mask. When `cfg_wr_en`=1 and `cfg_wr_sel`=0, `cfg_wr_data` is a write-1-to-clear to the pending register. After reset the mask, the pending bits and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | 8 | External request pins, active low, asynchronous |
| irq_edge_mode | input | 8 | Per-pin capture mode: 1 edge, 0 level |
| periph_req | input | 4 | Peripheral request lines |
| periph_lvl_sel | input | 12 | 3-bit level selector for each peripheral |
| wdog_in | input | 1 | Watchdog request to the non-maskable path |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 1 | 1 loads the mask, 0 clears pending bits |
| cfg_wr_data | input | 16 | Write data |
| pend_o | output | 16 | Pending register |
| irq_o | output | 1 | Maskable request to the core |
| nmi_o | output | 1 | Non-maskable request to the core |
| int_code | output | 8 | Code of the winning enabled pending source |

## Verification
Some properties are checked by assertions on every cycle:
- the request line tracks the enabled pending set one cycle later;
- the code is aligned to four, stays in range, and names the lowest-numbered enabled pending bit;
- the non-maskable line follows pin 0 and the watchdog;
- a captured edge bit survives unless it is cleared;
- mask writes land in the mask.

Other behaviour only the bench scenarios can show:
- the exact synchronizer latency;
- the rule that a held-low pin cannot set a bit again;
- a clear that collides with a new edge;
- a clear that level-mode bits ignore;
- peripherals sharing one routed level.

// File: rtl/ilv_intc_pkg.sv
package ilv_intc_pkg;
  localparam int CODE_W   = 8;
  localparam int CODE_LSB = 2;

  function automatic logic [CODE_W-1:0] rank_to_code(input logic [5:0] rank);
    logic [CODE_W-1:0] c;
    c = '0;
    c[CODE_LSB +: 6] = rank;
    return c;
  endfunction
endpackage

// File: rtl/ilv_pin_front.sv
module ilv_pin_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr,
  output logic pend
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   act_d;
  logic                   act;

  assign act = ~sync_q[LAST];

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '1;
        else        sync_q <= pin_n;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[LAST-1:0], pin_n};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_d <= 1'b0;
      pend  <= 1'b0;
    end else begin
      act_d <= act;
      if (!edge_mode)          pend <= act;
      else if (act && !act_d)  pend <= 1'b1;
      else if (clr)            pend <= 1'b0;
    end
  end
endmodule

// File: rtl/ilv_level_route.sv
module ilv_level_route #(
  parameter int NUM_PERIPH = 4,
  parameter int NUM_LVL    = 8,
  parameter int SEL_W      = 3
) (
  input  logic [NUM_PERIPH-1:0]       req,
  input  logic [NUM_PERIPH*SEL_W-1:0] sel,
  output logic [NUM_LVL-1:0]          lvl
);
  always_comb begin
    lvl = '0;
    for (int p = 0; p < NUM_PERIPH; p++)
      for (int l = 0; l < NUM_LVL; l++)
        if (req[p] && (sel[p*SEL_W +: SEL_W] == SEL_W'(l)))
          lvl[l] = 1'b1;
  end
endmodule

// File: rtl/ilv_prio_enc.sv
module ilv_prio_enc #(
  parameter int N  = 16,
  parameter int RW = 4
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [RW-1:0] rank
);
  always_comb begin
    any  = 1'b0;
    rank = '0;
    for (int i = N - 1; i >= 0; i--)
      if (vec[i]) begin
        any  = 1'b1;
        rank = RW'(i);
      end
  end
endmodule

// File: rtl/ilv_intc.sv
module ilv_intc
  import ilv_intc_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int NUM_PERIPH  = 4,
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PINS-1:0]         irq_pin_n,
  input  logic [NUM_PINS-1:0]         irq_edge_mode,
  input  logic [NUM_PERIPH-1:0]       periph_req,
  input  logic [NUM_PERIPH*SEL_W-1:0] periph_lvl_sel,
  input  logic                        wdog_in,
  input  logic                        cfg_wr_en,
  input  logic                        cfg_wr_sel,
  input  logic [2*NUM_PINS-1:0]       cfg_wr_data,
  output logic [2*NUM_PINS-1:0]       pend_o,
  output logic                        irq_o,
  output logic                        nmi_o,
  output logic [CODE_W-1:0]           int_code
);
  localparam int NSRC   = 2 * NUM_PINS;
  localparam int RANK_W = $clog2(NSRC);

  logic [NSRC-1:0]     pend_q;
  logic [NSRC-1:0]     mask_q;
  logic [NUM_PINS-1:0] pin_pend;
  logic [NUM_PINS-1:0] lvl_comb;
  logic [NUM_PINS-1:0] lvl_q;
  logic [NSRC-1:0]     clr_vec;
  logic [NSRC-1:0]     eff;
  logic                any;
  logic [RANK_W-1:0]   rank;
  logic                wdog_q;

  assign clr_vec = (cfg_wr_en && !cfg_wr_sel) ? cfg_wr_data : '0;

  generate
    for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
      ilv_pin_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_n     (irq_pin_n[k]),
        .edge_mode (irq_edge_mode[k]),
        .clr       (clr_vec[2*k]),
        .pend      (pin_pend[k])
      );
      assign pend_q[2*k]   = pin_pend[k];
      assign pend_q[2*k+1] = lvl_q[k];
    end
  endgenerate

  ilv_level_route #(
    .NUM_PERIPH (NUM_PERIPH),
    .NUM_LVL    (NUM_PINS),
    .SEL_W      (SEL_W)
  ) u_route (
    .req (periph_req),
    .sel (periph_lvl_sel),
    .lvl (lvl_comb)
  );

  // Rank 0 is non-maskable: it always competes for the code.
  assign eff = pend_q & {mask_q[NSRC-1:1], 1'b1};

  ilv_prio_enc #(.N(NSRC), .RW(RANK_W)) u_enc (
    .vec  (eff),
    .any  (any),
    .rank (rank)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q    <= '0;
      mask_q   <= '0;
      wdog_q   <= 1'b0;
      irq_o    <= 1'b0;
      nmi_o    <= 1'b0;
      int_code <= '0;
    end else begin
      lvl_q  <= lvl_comb;
      wdog_q <= wdog_in;
      if (cfg_wr_en && cfg_wr_sel) mask_q <= cfg_wr_data;
      irq_o    <= |(pend_q[NSRC-1:1] & mask_q[NSRC-1:1]);
      nmi_o    <= pend_q[0] | wdog_q;
      int_code <= any ? rank_to_code(6'(rank)) : '0;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/ilv_intc_chk.sv
module ilv_intc_chk #(
  parameter int NUM_PINS = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [2*NUM_PINS-1:0] pend,
  input logic [2*NUM_PINS-1:0] mask,
  input logic [NUM_PINS-1:0]   edge_mode,
  input logic                  cfg_wr_en,
  input logic                  cfg_wr_sel,
  input logic [2*NUM_PINS-1:0] cfg_wr_data,
  input logic                  wdog_q,
  input logic                  irq_o,
  input logic                  nmi_o,
  input logic [7:0]            int_code
);
  localparam int NSRC = 2 * NUM_PINS;

  logic [NSRC-1:0] eff_q;
  logic [3:0]      code_rank;
  assign code_rank = int_code[5:2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) eff_q <= '0;
    else        eff_q <= pend & {mask[NSRC-1:1], 1'b1};

  // R3, R4
  p_irq_tracks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == $past(|(pend[NSRC-1:1] & mask[NSRC-1:1])));

  // R2
  p_code_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (int_code[1:0] == 2'b00) && (int_code < 8'h40));

  // R1
  p_code_winner_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|eff_q) |-> (eff_q[code_rank] &&
                  ((eff_q & ((NSRC'(1) << code_rank) - NSRC'(1))) == '0)));

  // R8
  p_nmi_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[0] || wdog_q) |=> nmi_o);

  // R10
  p_mask_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_wr_sel) |=> (mask == $past(cfg_wr_data)));

  // R5
  generate
    for (genvar k = 0; k < NUM_PINS; k++) begin : g_sticky
      p_edge_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode[k] && pend[2*k] &&
         !(cfg_wr_en && !cfg_wr_sel && cfg_wr_data[2*k]))
        |=> (pend[2*k] || !edge_mode[k]));
    end
  endgenerate
endmodule

bind ilv_intc ilv_intc_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pend        (pend_q),
  .mask        (mask_q),
  .edge_mode   (irq_edge_mode),
  .cfg_wr_en   (cfg_wr_en),
  .cfg_wr_sel  (cfg_wr_sel),
  .cfg_wr_data (cfg_wr_data),
  .wdog_q      (wdog_q),
  .irq_o       (irq_o),
  .nmi_o       (nmi_o),
  .int_code    (int_code)
);

// File: tb/ilv_intc_bench.sv
module ilv_intc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_pin_n = 8'hFF;
  logic [7:0]  irq_edge_mode = 8'b1101_1011;
  logic [3:0]  periph_req = '0;
  logic [11:0] periph_lvl_sel = '0;
  logic        wdog_in = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic        cfg_wr_sel = 1'b0;
  logic [15:0] cfg_wr_data = '0;
  logic [15:0] pend_o;
  logic        irq_o, nmi_o;
  logic [7:0]  int_code;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  typedef struct {
    logic [7:0] code;
    logic       irq;
    logic       nmi;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  ilv_intc u_ilv_intc (
    .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .irq_edge_mode(irq_edge_mode),
    .periph_req(periph_req), .periph_lvl_sel(periph_lvl_sel), .wdog_in(wdog_in),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
    .pend_o(pend_o), .irq_o(irq_o), .nmi_o(nmi_o), .int_code(int_code)
  );

  // monitor: pops scoreboard items and compares against outputs
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      tests++;
      if (int_code !== e.code || irq_o !== e.irq || nmi_o !== e.nmi) begin
        fails++;
        $display("FAIL %s: code/irq/nmi actual %h/%b/%b expected %h/%b/%b",
                 e.tag, int_code, irq_o, nmi_o, e.code, e.irq, e.nmi);
      end
    end
  end

  task automatic expect_out(input logic [7:0] c, input logic i, input logic n, input string tag);
    exp_t e;
    e.code = c; e.irq = i; e.nmi = n; e.tag = tag;
    sb.push_back(e);
    repeat (2) @(negedge clk);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic cfg_write(input logic sel, input logic [15:0] d);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_wr_data = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(pend_o, 16'h0, "R10 reset pending");
    expect_out(8'h00, 1'b0, 1'b0, "R10 reset outputs");
    rst_n = 1'b1;
    @(negedge clk);
    cfg_write(1'b1, 16'hFFFF);

    // R5 edge capture on pin 3 -> bit 6, code 0x18 (R2)
    irq_pin_n[3] = 1'b0; settle();
    chk(pend_o, 16'h0040, "R5 edge capture");
    expect_out(8'h18, 1'b1, 1'b0, "R2 code for pin 3");
    irq_pin_n[3] = 1'b1; settle();
    chk(pend_o, 16'h0040, "R5 sticky after release");
    cfg_write(1'b0, 16'h0040); settle();
    chk(pend_o, 16'h0000, "R5 write-1 clear");
    expect_out(8'h00, 1'b0, 1'b0, "R4 drop after clear");

    // R5 held-low pin does not re-set
    irq_pin_n[3] = 1'b0; settle();
    cfg_write(1'b0, 16'h0040); settle();
    chk(pend_o, 16'h0000, "R5 held low no re-set");
    irq_pin_n[3] = 1'b1; settle();

    // R1 pin 2 (level mode) vs PIT on level 2; R9 routing
    periph_lvl_sel[2:0] = 3'd2; periph_req[0] = 1'b1;
    irq_pin_n[2] = 1'b0; settle();
    chk(pend_o, 16'h0030, "R1 pin and level pending");
    expect_out(8'h10, 1'b1, 1'b0, "R1 pin beats same-index level");
    cfg_write(1'b0, 16'h0030); settle();
    chk(pend_o, 16'h0030, "R6 clear ignored in level mode");
    irq_pin_n[2] = 1'b1; settle();
    chk(pend_o, 16'h0020, "R6 level bit follows pin");
    expect_out(8'h14, 1'b1, 1'b0, "R1 level 2 wins alone");

    // R4 masking: drop one cycle after mask write
    cfg_write(1'b1, 16'hFFDF);
    chk({31'd0, irq_o}, 32'd1, "R4 irq before mask takes effect");
    @(negedge clk);
    chk({31'd0, irq_o}, 32'd0, "R4 irq drop after mask");
    expect_out(8'h00, 1'b0, 1'b0, "R3 masked source silent");
    cfg_write(1'b1, 16'hFFFF);
    periph_req[0] = 1'b0; settle();
    chk(pend_o, 16'h0000, "R9 level released");

    // R7 latency on pin 4 (bit 8)
    irq_pin_n[4] = 1'b0;
    repeat (2) @(negedge clk);
    chk(pend_o, 16'h0000, "R7 not yet pending after 2 edges");
    @(negedge clk);
    chk(pend_o, 16'h0100, "R7 pending on 3rd edge");
    chk({31'd0, irq_o}, 32'd0, "R7 irq not yet on 3rd edge");
    @(negedge clk);
    chk({31'd0, irq_o}, 32'd1, "R7 irq on 4th edge");
    expect_out(8'h20, 1'b1, 1'b0, "R7 code pin 4");
    irq_pin_n[4] = 1'b1;
    cfg_write(1'b0, 16'h0100); settle();

    // R8 pin 0 to NMI, ignores mask
    irq_pin_n[0] = 1'b0; settle();
    chk(pend_o, 16'h0001, "R8 pin 0 pending");
    expect_out(8'h00, 1'b0, 1'b1, "R8 pin 0 to nmi only");
    cfg_write(1'b1, 16'hFFFE); settle();
    expect_out(8'h00, 1'b0, 1'b1, "R8 mask bit 0 no effect");
    cfg_write(1'b1, 16'hFFFF);
    irq_pin_n[0] = 1'b1;
    cfg_write(1'b0, 16'h0001); settle();
    expect_out(8'h00, 1'b0, 1'b0, "R8 nmi released");
    wdog_in = 1'b1;
    @(negedge clk);
    chk({31'd0, nmi_o}, 32'd0, "R8 watchdog nmi not after 1 edge");
    @(negedge clk);
    chk({31'd0, nmi_o}, 32'd1, "R8 watchdog nmi after 2 edges");
    wdog_in = 1'b0; settle();

    // R9 routing: RTC and time base to level 7, comm to level 6
    periph_lvl_sel[5:3] = 3'd7; periph_req[1] = 1'b1; settle();
    chk(pend_o, 16'h8000, "R9 rtc on level 7");
    expect_out(8'h3C, 1'b1, 1'b0, "R2 lowest rank code");
    periph_lvl_sel[8:6] = 3'd7; periph_req[2] = 1'b1;
    periph_req[1] = 1'b0; settle();
    chk(pend_o, 16'h8000, "R9 shared level ORed");
    periph_lvl_sel[11:9] = 3'd6; periph_req[3] = 1'b1; settle();
    chk(pend_o, 16'hA000, "R9 comm on level 6");
    expect_out(8'h34, 1'b1, 1'b0, "R1 level 6 above level 7");
    periph_req = '0; settle();

    // R5 set beats clear in same cycle (pin 6 -> bit 12)
    irq_pin_n[6] = 1'b0;
    repeat (2) @(negedge clk);
    cfg_write(1'b0, 16'h1000); settle();
    chk(pend_o, 16'h1000, "R5 edge beats clear");
    irq_pin_n[6] = 1'b1;
    cfg_write(1'b0, 16'h1000); settle();

    // R1 edge pin 1 vs comm on level 1 simultaneously
    periph_lvl_sel[11:9] = 3'd1;
    irq_pin_n[1] = 1'b0; periph_req[3] = 1'b1; settle();
    chk(pend_o, 16'h000C, "R1 pin 1 and level 1");
    expect_out(8'h08, 1'b1, 1'b0, "R1 pin 1 first");

    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule